// File: doc/BRIEF.md
# Four-Mode Timer/Counter With Machine-Cycle Divider

This block is one 16-bit timer/counter for an 8-bit controller core. It keeps a low byte and a high byte that software can read and write. Software reaches it through a byte-wide special-function-register bus with an address, a write strobe, write data and combinational read data. It runs on the oscillator clock. A free-running divider turns that clock into one machine-cycle tick every `OSC_PER_MC` clocks, and counting only happens on those ticks.

A configuration register picks the clock source and the counting structure. In timer mode the count advances on every machine cycle. In counter mode it advances on falling edges of an external count pin, which is sampled once per machine cycle. A gate option lets an external gate pin hold counting off, so software can measure the width of a pulse on that pin.

There are four counting structures:
- a 13-bit count made of a 5-bit prescaler that carries into the high byte;
- a plain 16-bit count;
- an 8-bit count that reloads itself from the high byte;
- a split mode in which the high byte is a second, independent 8-bit timer.

Overflows set sticky flags. The flags are also driven to output pins so they can raise interrupt requests.

Top module: `mtc_timer`

## Requirements
- R1: After reset, every register reads 0x00: control at 0x88, configuration at 0x89, low byte at 0x8A and high byte at 0x8C. Both overflow outputs are low.
- R2: The configuration register keeps bits 3:0 and reads 0 in bits 7:4. Its fields are gate enable (bit 3), external count select (bit 2) and mode (bits 1:0). The control register keeps bits 7:4 and reads 0 in bits 3:0. Its fields are high-byte overflow flag (bit 7), high-byte run (bit 6), main overflow flag (bit 5) and main run (bit 4).
- R3: In timer mode (bit 2 = 0) an enabled count advances by exactly one per `OSC_PER_MC` (12) oscillator clocks.
- R4: In counter mode (bit 2 = 1) the count advances once for each falling edge on the count pin. An edge is seen when one machine-cycle sample reads 1 and the next sample reads 0.
- R5: The main count is enabled only when run (bit 4) is 1 and either gate enable is 0 or the gate pin is high.
- R6: In mode 00 the low 5 bits of the low byte form a prescaler that carries into the high byte. The low byte's bits 7:5 are left unchanged. The main overflow flag sets when the 13-bit value wraps from all ones to zero.
- R7: In mode 01 the low and high bytes form one 16-bit count. The main overflow flag sets when it wraps from 0xFFFF to 0x0000.
- R8: In mode 10 the low byte counts up. On its wrap it loads the high byte's value in the same cycle and sets the main overflow flag. The high byte never changes except when software writes it.
- R9: In mode 11 the low byte counts under the main run, gate and source controls, and its wrap sets the main overflow flag. The high byte counts machine cycles whenever high-byte run (bit 6) is 1, ignoring both pins. Its wrap from 0xFF sets the high-byte overflow flag.
- R10: A software write to the low or high byte wins over a count update to that byte in the same clock.
- R11: Overflow flags stay set until software writes the control register. A hardware set in the same clock as a software write leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sfr_addr | input | 8 | Register address |
| sfr_we | input | 1 | Write strobe, one clock per write |
| sfr_wdata | input | 8 | Write data |
| sfr_rdata | output | 8 | Read data for the addressed register (combinational) |
| cnt_pin | input | 1 | External count input |
| gate_pin | input | 1 | External gate input |
| ovf_main | output | 1 | Main overflow flag |
| ovf_high | output | 1 | High-byte overflow flag (split mode) |

## Verification
A register write shows on the read data one clock after its strobe. A count update lands on the clock edge that carries the machine-cycle tick.

The pins pass through `SYNC_STAGES` flops before they are sampled. A gate-pin window of 12·N clocks therefore always yields exactly N counted ticks, whatever the divider phase, because the delay is the same at both ends of the window.

The bench builds each run from such windows. Where a result must land on one particular edge, it first finds the divider phase by polling the low byte until it changes. It then times the stimulus from that point: one tick later for the rate check, and in the same clock as the tick for the write-priority check. It always samples on the falling edge after the register concerned has updated.

// File: rtl/mtc_pkg.sv
package mtc_pkg;
   localparam int BYTE_W = 8;

   localparam logic [7:0] ADDR_CTRL = 8'h88;
   localparam logic [7:0] ADDR_CFG  = 8'h89;
   localparam logic [7:0] ADDR_LO   = 8'h8A;
   localparam logic [7:0] ADDR_HI   = 8'h8C;

   typedef enum logic [1:0] {
      MD_PRE13   = 2'b00,
      MD_WIDE16  = 2'b01,
      MD_RELOAD8 = 2'b10,
      MD_SPLIT   = 2'b11
   } mtc_mode_e;

   // configuration register, bits 3:0
   typedef struct packed {
      logic      gate_en;
      logic      ext_src;
      mtc_mode_e md;
   } mtc_cfg_t;

   // control register, bits 7:4
   typedef struct packed {
      logic ovf_hi;
      logic run_hi;
      logic ovf_lo;
      logic run_lo;
   } mtc_ctl_t;
endpackage

// File: rtl/mtc_mc_div.sv
module mtc_mc_div #(
   parameter int OSC_PER_MC = 12
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int CW = (OSC_PER_MC > 1) ? $clog2(OSC_PER_MC) : 1;
   localparam logic [CW-1:0] LAST = CW'(OSC_PER_MC - 1);

   logic [CW-1:0] phase_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            phase_q <= '0;
      else if (phase_q == LAST) phase_q <= '0;
      else                   phase_q <= phase_q + 1'b1;
   end

   assign tick = (phase_q == LAST);
endmodule

// File: rtl/mtc_pin_sync.sv
module mtc_pin_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   generate
      if (STAGES == 0) begin : g_direct
         assign dout = din;
      end else begin : g_chain
         logic [STAGES-1:0] sh_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= '0;
            else        sh_q <= {sh_q[STAGES-2 >= 0 ? STAGES-2 : 0 : 0], din} >> ((STAGES == 1) ? 0 : 0);
         end
         assign dout = sh_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/mtc_edge.sv
module mtc_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic pin,
   output logic fall
);
   logic smp_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    smp_q <= 1'b0;
      else if (tick) smp_q <= pin;
   end

   // previous machine-cycle sample high, current sample low
   assign fall = tick & smp_q & ~pin;
endmodule

// File: rtl/mtc_count.sv
module mtc_count
   import mtc_pkg::*;
#(
   parameter int PRE_BITS = 5
) (
   input  mtc_mode_e         md,
   input  logic [BYTE_W-1:0] lo,
   input  logic [BYTE_W-1:0] hi,
   input  logic              inc_lo,
   input  logic              inc_hi,
   output logic [BYTE_W-1:0] lo_nx,
   output logic [BYTE_W-1:0] hi_nx,
   output logic              set_ovf_lo,
   output logic              set_ovf_hi
);
   localparam int PW = BYTE_W + PRE_BITS;
   localparam logic [BYTE_W-1:0] PMASK = BYTE_W'((1 << PRE_BITS) - 1);

   logic [PW:0]         sum_pre;
   logic [2*BYTE_W:0]   sum_wide;
   logic [BYTE_W:0]     sum_lo;
   logic [BYTE_W:0]     sum_hi;
   logic [BYTE_W-1:0]   pre_low;

   assign sum_pre  = {1'b0, hi, lo[PRE_BITS-1:0]} + 1'b1;
   assign sum_wide = {1'b0, hi, lo} + 1'b1;
   assign sum_lo   = {1'b0, lo} + 1'b1;
   assign sum_hi   = {1'b0, hi} + 1'b1;
   assign pre_low  = BYTE_W'(sum_pre[PRE_BITS-1:0]);

   always_comb begin
      lo_nx      = lo;
      hi_nx      = hi;
      set_ovf_lo = 1'b0;
      set_ovf_hi = 1'b0;
      unique case (md)
         MD_PRE13: if (inc_lo) begin
            lo_nx      = (lo & ~PMASK) | (pre_low & PMASK);
            hi_nx      = sum_pre[PW-1:PRE_BITS];
            set_ovf_lo = sum_pre[PW];
         end
         MD_WIDE16: if (inc_lo) begin
            lo_nx      = sum_wide[BYTE_W-1:0];
            hi_nx      = sum_wide[2*BYTE_W-1:BYTE_W];
            set_ovf_lo = sum_wide[2*BYTE_W];
         end
         MD_RELOAD8: if (inc_lo) begin
            lo_nx      = sum_lo[BYTE_W] ? hi : sum_lo[BYTE_W-1:0];
            set_ovf_lo = sum_lo[BYTE_W];
         end
         MD_SPLIT: begin
            if (inc_lo) begin
               lo_nx      = sum_lo[BYTE_W-1:0];
               set_ovf_lo = sum_lo[BYTE_W];
            end
            if (inc_hi) begin
               hi_nx      = sum_hi[BYTE_W-1:0];
               set_ovf_hi = sum_hi[BYTE_W];
            end
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/mtc_timer.sv
module mtc_timer
   import mtc_pkg::*;
#(
   parameter int OSC_PER_MC  = 12,
   parameter int SYNC_STAGES = 2,
   parameter int PRE_BITS    = 5
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [7:0] sfr_addr,
   input  logic       sfr_we,
   input  logic [7:0] sfr_wdata,
   output logic [7:0] sfr_rdata,
   input  logic       cnt_pin,
   input  logic       gate_pin,
   output logic       ovf_main,
   output logic       ovf_high
);
   generate
      if (OSC_PER_MC < 2)                  begin : g_bad_div  $error("OSC_PER_MC must be at least 2"); end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync $error("SYNC_STAGES must be 0..4"); end
      if (PRE_BITS < 1 || PRE_BITS > 7)    begin : g_bad_pre  $error("PRE_BITS must be 1..7"); end
   endgenerate

   logic [BYTE_W-1:0] lo_q, hi_q, lo_nx, hi_nx;
   mtc_cfg_t          cfg_q;
   mtc_ctl_t          ctl_q;
   mtc_mode_e         md_w;
   logic              mc_tick, cnt_s, gate_s, cnt_fall;
   logic              inc_lo, inc_hi, set_lo, set_hi;
   logic              wr_ctl, wr_cfg, wr_lo, wr_hi;

   mtc_mc_div #(.OSC_PER_MC(OSC_PER_MC)) i_div (
      .clk(clk), .rst_n(rst_n), .tick(mc_tick));

   mtc_pin_sync #(.STAGES(SYNC_STAGES)) i_sync_cnt (
      .clk(clk), .rst_n(rst_n), .din(cnt_pin), .dout(cnt_s));

   mtc_pin_sync #(.STAGES(SYNC_STAGES)) i_sync_gate (
      .clk(clk), .rst_n(rst_n), .din(gate_pin), .dout(gate_s));

   mtc_edge i_edge (
      .clk(clk), .rst_n(rst_n), .tick(mc_tick), .pin(cnt_s), .fall(cnt_fall));

   assign md_w   = cfg_q.md;
   assign wr_ctl = sfr_we && (sfr_addr == ADDR_CTRL);
   assign wr_cfg = sfr_we && (sfr_addr == ADDR_CFG);
   assign wr_lo  = sfr_we && (sfr_addr == ADDR_LO);
   assign wr_hi  = sfr_we && (sfr_addr == ADDR_HI);

   assign inc_lo = ctl_q.run_lo && (!cfg_q.gate_en || gate_s) &&
                   (cfg_q.ext_src ? cnt_fall : mc_tick);
   assign inc_hi = mc_tick && ctl_q.run_hi && (md_w == MD_SPLIT);

   mtc_count #(.PRE_BITS(PRE_BITS)) i_count (
      .md(md_w), .lo(lo_q), .hi(hi_q), .inc_lo(inc_lo), .inc_hi(inc_hi),
      .lo_nx(lo_nx), .hi_nx(hi_nx), .set_ovf_lo(set_lo), .set_ovf_hi(set_hi));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q  <= '0;
         hi_q  <= '0;
         cfg_q <= '0;
         ctl_q <= '0;
      end else begin
         lo_q <= wr_lo ? sfr_wdata : lo_nx;
         hi_q <= wr_hi ? sfr_wdata : hi_nx;
         if (wr_cfg) cfg_q <= mtc_cfg_t'(sfr_wdata[3:0]);
         if (wr_ctl) begin
            ctl_q.run_lo <= sfr_wdata[4];
            ctl_q.run_hi <= sfr_wdata[6];
         end
         ctl_q.ovf_lo <= (wr_ctl ? sfr_wdata[5] : ctl_q.ovf_lo) | set_lo;
         ctl_q.ovf_hi <= (wr_ctl ? sfr_wdata[7] : ctl_q.ovf_hi) | set_hi;
      end
   end

   always_comb begin
      unique case (sfr_addr)
         ADDR_CTRL: sfr_rdata = {ctl_q, 4'h0};
         ADDR_CFG:  sfr_rdata = {4'h0, cfg_q};
         ADDR_LO:   sfr_rdata = lo_q;
         ADDR_HI:   sfr_rdata = hi_q;
         default:   sfr_rdata = 8'h00;
      endcase
   end

   assign ovf_main = ctl_q.ovf_lo;
   assign ovf_high = ctl_q.ovf_hi;
endmodule

// File: rtl/mtc_timer_chk.sv
module mtc_timer_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [7:0] sfr_addr,
   input logic       sfr_we,
   input logic [7:0] sfr_wdata,
   input logic [7:0] lo,
   input logic [7:0] hi,
   input logic       tick,
   input logic [1:0] md,
   input logic       run_lo,
   input logic       ovf_main,
   input logic       ovf_high
);
   // R3: counting only moves on a machine-cycle tick
   a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !sfr_we) |=> ($stable(lo) && $stable(hi)));

   // R3: ticks are at least two clocks apart
   a_r3_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);

   // R5: main run off holds the count outside split mode
   a_r5_stopped: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_lo && md != 2'b11 && !sfr_we) |=> ($stable(lo) && $stable(hi)));

   // R8: reload source is untouched by counting
   a_r8_hi_fixed: assert property (@(posedge clk) disable iff (!rst_n)
      (md == 2'b10 && !(sfr_we && sfr_addr == 8'h8C)) |=> $stable(hi));

   // R10: a low-byte write always lands
   a_r10_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (sfr_we && sfr_addr == 8'h8A) |=> (lo == $past(sfr_wdata)));

   // R11: flags hold without a control write
   a_r11_main_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_main && !(sfr_we && sfr_addr == 8'h88)) |=> ovf_main);

   a_r11_high_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_high && !(sfr_we && sfr_addr == 8'h88)) |=> ovf_high);
endmodule

bind mtc_timer mtc_timer_chk i_chk (
   .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_we(sfr_we),
   .sfr_wdata(sfr_wdata), .lo(lo_q), .hi(hi_q), .tick(mc_tick),
   .md(md_w), .run_lo(ctl_q.run_lo), .ovf_main(ovf_main), .ovf_high(ovf_high));

// File: tb/test_mtc_timer.sv
module test_mtc_timer;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] sfr_addr = 8'h00;
   logic       sfr_we = 1'b0;
   logic [7:0] sfr_wdata = 8'h00;
   logic [7:0] sfr_rdata;
   logic       cnt_pin = 1'b0;
   logic       gate_pin = 1'b0;
   logic       ovf_main, ovf_high;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   localparam logic [7:0] A_CTRL = 8'h88, A_CFG = 8'h89, A_LO = 8'h8A, A_HI = 8'h8C;

   always #10 clk = ~clk;

   mtc_timer i_mtc_timer (
      .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_we(sfr_we),
      .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .cnt_pin(cnt_pin),
      .gate_pin(gate_pin), .ovf_main(ovf_main), .ovf_high(ovf_high));

   // {mode, hi0, lo0, ticks, exp_hi, exp_lo, exp_ovf}
   localparam int NV = 9;
   localparam logic [42:0] VEC [NV] = '{
      {2'd1, 8'h00, 8'hFE - 8'hFE, 8'd5, 8'h00, 8'h05, 1'b0}, // R7
      {2'd1, 8'h12, 8'hFE, 8'd3, 8'h13, 8'h01, 1'b0},         // R7 carry
      {2'd1, 8'hFF, 8'hFE, 8'd3, 8'h00, 8'h01, 1'b1},         // R7 wrap
      {2'd0, 8'h00, 8'h1E, 8'd3, 8'h01, 8'h01, 1'b0},         // R6 carry
      {2'd0, 8'hFF, 8'h1F, 8'd2, 8'h00, 8'h01, 1'b1},         // R6 wrap
      {2'd0, 8'h05, 8'hE0, 8'd4, 8'h05, 8'hE4, 1'b0},         // R6 upper bits kept
      {2'd2, 8'h80, 8'hFE, 8'd3, 8'h80, 8'h81, 1'b1},         // R8 reload
      {2'd2, 8'h40, 8'h10, 8'd5, 8'h40, 8'h15, 1'b0},         // R8 plain
      {2'd3, 8'h33, 8'hFE, 8'd3, 8'h33, 8'h01, 1'b1}          // R9 low byte
   };

   task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got=%02h exp=%02h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      sfr_addr = a; sfr_wdata = d; sfr_we = 1'b1;
      @(negedge clk);
      sfr_we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] v);
      sfr_addr = a;
      #1;
      v = sfr_rdata;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [7:0] v, v0;
      string mtag [4] = '{"R6", "R7", "R8", "R9"};
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(A_CTRL, v); chk("R1 ctrl", v, 8'h00);
      rd(A_CFG, v);  chk("R1 cfg", v, 8'h00);
      rd(A_LO, v);   chk("R1 lo", v, 8'h00);
      rd(A_HI, v);   chk("R1 hi", v, 8'h00);
      chk("R1 flags", {6'b0, ovf_high, ovf_main}, 8'h00);

      // R2 field layout
      wr(A_CFG, 8'hFF);  rd(A_CFG, v);  chk("R2 cfg readback", v, 8'h0F);
      wr(A_CTRL, 8'h5F); rd(A_CTRL, v); chk("R2 ctrl readback", v, 8'h50);
      wr(A_CTRL, 8'h00); wr(A_CFG, 8'h00);

      // vector table: gated timer windows of 12*N clocks (R3, R5)
      for (int i = 0; i < NV; i++) begin
         logic [1:0] md; logic [7:0] h0, l0, n, eh, el; logic eo;
         {md, h0, l0, n, eh, el, eo} = VEC[i];
         wr(A_CTRL, 8'h00);
         wr(A_CFG, {6'b000010, md});
         wr(A_HI, h0);
         wr(A_LO, l0);
         wr(A_CTRL, 8'h10);
         gate_pin = 1'b1;
         repeat (12 * int'(n)) @(negedge clk);
         gate_pin = 1'b0;
         repeat (8) @(negedge clk);
         rd(A_LO, v);   chk({mtag[md], " R3 R5 lo"}, v, el);
         rd(A_HI, v);   chk({mtag[md], " R3 R5 hi"}, v, eh);
         rd(A_CTRL, v); chk({mtag[md], " ovf flag"}, {7'b0, v[5]}, {7'b0, eo});
      end

      // R11 flag sticky, then cleared by software
      repeat (100) @(negedge clk);
      rd(A_CTRL, v); chk("R11 still set", {7'b0, v[5]}, 8'h01);
      wr(A_CTRL, 8'h00);
      rd(A_CTRL, v); chk("R11 cleared", {7'b0, v[5]}, 8'h00);

      // R5 gate low blocks counting
      wr(A_CFG, 8'h09); wr(A_HI, 8'h00); wr(A_LO, 8'h00); wr(A_CTRL, 8'h10);
      repeat (240) @(negedge clk);
      rd(A_LO, v); chk("R5 gated off", v, 8'h00);
      wr(A_CTRL, 8'h00);

      // R4 counter mode, four pin pulses of two machine cycles per level
      wr(A_CFG, 8'h05); wr(A_LO, 8'h00); wr(A_CTRL, 8'h10);
      repeat (40) @(negedge clk);
      rd(A_LO, v); chk("R4 no edges", v, 8'h00);
      for (int p = 0; p < 4; p++) begin
         cnt_pin = 1'b1; repeat (24) @(negedge clk);
         cnt_pin = 1'b0; repeat (24) @(negedge clk);
      end
      rd(A_LO, v); chk("R4 four edges", v, 8'h04);
      wr(A_CTRL, 8'h00);

      // R9 high byte in split mode, pins ignored
      wr(A_CFG, 8'h0B); wr(A_LO, 8'h00); wr(A_HI, 8'hFD);
      wr(A_CTRL, 8'h40);
      repeat (36) @(negedge clk);
      rd(A_CTRL, v); chk("R9 high flag", {7'b0, v[7]}, 8'h01);
      chk("R9 high flag pin", {7'b0, ovf_high}, 8'h01);
      repeat (11) @(negedge clk);
      wr(A_CTRL, 8'h00);
      rd(A_HI, v); chk("R9 high count", v, 8'h01);
      rd(A_LO, v); chk("R9 low gated", v, 8'h00);

      // R3 exact rate and R10 write priority, aligned to the divider
      wr(A_CFG, 8'h01); wr(A_HI, 8'h00); wr(A_LO, 8'h00); wr(A_CTRL, 8'h10);
      rd(A_LO, v0);
      for (int k = 0; k < 30; k++) begin
         @(negedge clk); rd(A_LO, v);
         if (v != v0) break;
      end
      v0 = v;
      repeat (11) @(negedge clk);
      rd(A_LO, v); chk("R3 before tick", v, v0);
      @(negedge clk);
      rd(A_LO, v); chk("R3 one tick", v, v0 + 8'h01);
      repeat (11) @(negedge clk);
      wr(A_LO, 8'h55);
      rd(A_LO, v); chk("R10 write over tick", v, 8'h55);
      wr(A_CTRL, 8'h00);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule